// File: doc/BRIEF.md
# Function Level Reset Tracker

The block records host-initiated function level resets for a device with two physical functions and six virtual functions. A trigger pulse from the configuration-space logic marks one function as being reset. That function's active bit goes high, and its configuration-access enable goes low. The bit stays set until user logic reports completion on the matching done bit. A completion clears the bit and restores configuration access to that function.

Physical functions use 4-bit vectors and virtual functions use 8-bit vectors. The upper slots of each vector are reserved: bits [3:2] of the physical vectors and bits [7:6] of the virtual vectors. Reserved slots hold no state and always read zero.

The reset input is asynchronous and active-low, and the block releases it synchronously through two internal flops.

Top module: `flr_tracker`

## Requirements
- R1: While rst_n is low, and after it is released, every active bit reads 0 and the configuration enable reads 1 for every implemented function (pf bits [1:0], vf bits [5:0]), until a trigger arrives.
- R2: A trigger bit i high at a rising edge makes active bit i read 1 after that edge.
- R3: An active bit stays 1 on every later edge at which its done bit is low.
- R4: A done bit i high at an edge where active bit i is 1 and trigger bit i is low makes active bit i read 0 after that edge.
- R5: A done bit for a function whose active bit is 0 has no effect. The active bit stays 0 and no other bit changes.
- R6: If trigger bit i and done bit i are both high at the same edge, active bit i reads 1 after that edge.
- R7: A trigger for a function that is already active leaves it active.
- R8: Reserved bits always read 0 on both active outputs and both enable outputs, whatever their trigger and done inputs do. These are pf bits [3:2] and vf bits [7:6].
- R9: For each implemented function the configuration enable output is the inverse of its active bit.
- R10: The inputs of one function never change the active bit of another function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_flr_trig | input | 4 | Host reset trigger per physical function |
| vf_flr_trig | input | 8 | Host reset trigger per virtual function |
| pf_flr_done | input | 4 | User completion per physical function |
| vf_flr_done | input | 8 | User completion per virtual function |
| pf_flr_active | output | 4 | Reset in progress per physical function |
| vf_flr_active | output | 8 | Reset in progress per virtual function |
| pf_cfg_ok | output | 4 | Configuration access allowed per physical function |
| vf_cfg_ok | output | 8 | Configuration access allowed per virtual function |

## Verification
The assertions assume that trigger and done inputs are synchronous to clk and stable around each rising edge. They also assume that the first cycle after reset release holds no meaningful history, so they arm one cycle later. The bench changes its inputs only on falling edges and drops them right after the sampling edge, so each pulse lasts exactly one cycle. It drives all-ones patterns onto the reserved slots deliberately, to show that those slots ignore any input value.

// File: rtl/flr_pkg.sv
package flr_pkg;
  localparam int PF_SLOTS = 4;
  localparam int PF_USED  = 2;
  localparam int VF_SLOTS = 8;
  localparam int VF_USED  = 6;
endpackage

// File: rtl/flr_rst_sync.sv
module flr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/flr_slot.sv
module flr_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic done,
  output logic active
);
  logic active_q;
  logic active_d;
  logic upd;

  // trigger has priority over completion
  always_comb begin
    upd      = trig | (done & active_q);
    active_d = trig ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   active_q <= 1'b0;
    else if (upd) active_q <= active_d;
  end

  assign active = active_q;
endmodule

// File: rtl/flr_bank.sv
module flr_bank #(
  parameter int SLOTS = 4,
  parameter int USED  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] trig,
  input  logic [SLOTS-1:0] done,
  output logic [SLOTS-1:0] active,
  output logic [SLOTS-1:0] cfg_ok
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < USED) begin : g_impl
      flr_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig[i]),
        .done   (done[i]),
        .active (active[i])
      );
      assign cfg_ok[i] = ~active[i];
    end else begin : g_rsvd
      logic unused_in;
      assign unused_in = trig[i] ^ done[i];
      assign active[i] = 1'b0;
      assign cfg_ok[i] = 1'b0;
    end
  end
endmodule

// File: rtl/flr_tracker.sv
module flr_tracker
  import flr_pkg::*;
#(
  parameter int PF_W = PF_SLOTS,
  parameter int PF_N = PF_USED,
  parameter int VF_W = VF_SLOTS,
  parameter int VF_N = VF_USED
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PF_W-1:0] pf_flr_trig,
  input  logic [VF_W-1:0] vf_flr_trig,
  input  logic [PF_W-1:0] pf_flr_done,
  input  logic [VF_W-1:0] vf_flr_done,
  output logic [PF_W-1:0] pf_flr_active,
  output logic [VF_W-1:0] vf_flr_active,
  output logic [PF_W-1:0] pf_cfg_ok,
  output logic [VF_W-1:0] vf_cfg_ok
);
  logic rst_q_n;

  flr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  flr_bank #(.SLOTS(PF_W), .USED(PF_N)) u_pf (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .trig   (pf_flr_trig),
    .done   (pf_flr_done),
    .active (pf_flr_active),
    .cfg_ok (pf_cfg_ok)
  );

  flr_bank #(.SLOTS(VF_W), .USED(VF_N)) u_vf (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .trig   (vf_flr_trig),
    .done   (vf_flr_done),
    .active (vf_flr_active),
    .cfg_ok (vf_cfg_ok)
  );
endmodule

// File: rtl/flr_tracker_chk.sv
module flr_tracker_chk #(
  parameter int PF_W = 4,
  parameter int PF_N = 2,
  parameter int VF_W = 8,
  parameter int VF_N = 6
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic [PF_W-1:0] pf_flr_trig,
  input logic [VF_W-1:0] vf_flr_trig,
  input logic [PF_W-1:0] pf_flr_done,
  input logic [VF_W-1:0] vf_flr_done,
  input logic [PF_W-1:0] pf_flr_active,
  input logic [VF_W-1:0] vf_flr_active,
  input logic [PF_W-1:0] pf_cfg_ok,
  input logic [VF_W-1:0] vf_cfg_ok
);
  localparam logic [PF_W-1:0] PFM = {PF_W{1'b1}} >> (PF_W - PF_N);
  localparam logic [VF_W-1:0] VFM = {VF_W{1'b1}} >> (VF_W - VF_N);

  logic armed;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R2 / R6 / R7: a trigger always leaves its bit set
  p_set_pf_r2: assert property (@(posedge clk) disable iff (!armed)
    ((pf_flr_active & $past(pf_flr_trig & PFM)) == $past(pf_flr_trig & PFM)));
  p_set_vf_r2: assert property (@(posedge clk) disable iff (!armed)
    ((vf_flr_active & $past(vf_flr_trig & VFM)) == $past(vf_flr_trig & VFM)));

  // R3: no completion, no clear
  p_hold_pf_r3: assert property (@(posedge clk) disable iff (!armed)
    ((pf_flr_active & $past(pf_flr_active & ~pf_flr_done)) == $past(pf_flr_active & ~pf_flr_done)));
  p_hold_vf_r3: assert property (@(posedge clk) disable iff (!armed)
    ((vf_flr_active & $past(vf_flr_active & ~vf_flr_done)) == $past(vf_flr_active & ~vf_flr_done)));

  // R4: completion without trigger clears
  p_clear_pf_r4: assert property (@(posedge clk) disable iff (!armed)
    ((pf_flr_active & $past(pf_flr_done & ~pf_flr_trig)) == '0));
  p_clear_vf_r4: assert property (@(posedge clk) disable iff (!armed)
    ((vf_flr_active & $past(vf_flr_done & ~vf_flr_trig)) == '0));

  // R5 / R10: a bit rises only on its own trigger
  p_rise_pf_r10: assert property (@(posedge clk) disable iff (!armed)
    ((pf_flr_active & ~$past(pf_flr_active) & ~$past(pf_flr_trig)) == '0));
  p_rise_vf_r10: assert property (@(posedge clk) disable iff (!armed)
    ((vf_flr_active & ~$past(vf_flr_active) & ~$past(vf_flr_trig)) == '0));

  // R8: reserved slots read zero
  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (((pf_flr_active | pf_cfg_ok) & ~PFM) == '0) && (((vf_flr_active | vf_cfg_ok) & ~VFM) == '0));

  // R9: access enable mirrors active bit
  p_cfg_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((pf_cfg_ok ^ pf_flr_active) & PFM) == PFM && ((vf_cfg_ok ^ vf_flr_active) & VFM) == VFM);
endmodule

bind flr_tracker flr_tracker_chk #(
  .PF_W(PF_W), .PF_N(PF_N), .VF_W(VF_W), .VF_N(VF_N)
) i_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .pf_flr_trig   (pf_flr_trig),
  .vf_flr_trig   (vf_flr_trig),
  .pf_flr_done   (pf_flr_done),
  .vf_flr_done   (vf_flr_done),
  .pf_flr_active (pf_flr_active),
  .vf_flr_active (vf_flr_active),
  .pf_cfg_ok     (pf_cfg_ok),
  .vf_cfg_ok     (vf_cfg_ok)
);

// File: tb/test_flr_tracker.sv
`timescale 1ns/1ps
module test_flr_tracker;
  logic       clk;
  logic       rst_n;
  logic [3:0] pf_flr_trig, pf_flr_done, pf_flr_active, pf_cfg_ok;
  logic [7:0] vf_flr_trig, vf_flr_done, vf_flr_active, vf_cfg_ok;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  flr_tracker i_flr_tracker (
    .clk(clk), .rst_n(rst_n),
    .pf_flr_trig(pf_flr_trig), .vf_flr_trig(vf_flr_trig),
    .pf_flr_done(pf_flr_done), .vf_flr_done(vf_flr_done),
    .pf_flr_active(pf_flr_active), .vf_flr_active(vf_flr_active),
    .pf_cfg_ok(pf_cfg_ok), .vf_cfg_ok(vf_cfg_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] pt, input logic [7:0] vt,
                      input logic [3:0] pd, input logic [7:0] vd);
    @(negedge clk);
    pf_flr_trig = pt; vf_flr_trig = vt; pf_flr_done = pd; vf_flr_done = vd;
    @(posedge clk);
    #1;
    pf_flr_trig = '0; vf_flr_trig = '0; pf_flr_done = '0; vf_flr_done = '0;
  endtask

  task automatic expect_state(input string req, input logic [3:0] pa, input logic [7:0] va);
    check(req, {4'h0, pf_flr_active}, {4'h0, pa});
    check(req, vf_flr_active, va);
    check({req, "/R9"}, {4'h0, pf_cfg_ok}, {4'h0, ~pa & 4'h3});
    check({req, "/R9"}, vf_cfg_ok, ~va & 8'h3F);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    pf_flr_trig = '0; vf_flr_trig = '0; pf_flr_done = '0; vf_flr_done = '0;
    repeat (3) @(posedge clk);
    #1;
    expect_state("R1 in reset", 4'h0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_state("R1 after release", 4'h0, 8'h00);
  endtask

  task automatic t_set_hold;
    step(4'h1, 8'h00, 4'h0, 8'h00);
    expect_state("R2 pf0 set", 4'h1, 8'h00);
    step(4'h0, 8'h08, 4'h0, 8'h00);
    expect_state("R10 vf3 set, pf0 kept", 4'h1, 8'h08);
    repeat (4) step(4'h0, 8'h00, 4'h0, 8'h00);
    expect_state("R3 hold idle", 4'h1, 8'h08);
    step(4'h0, 8'h00, 4'h0, 8'h04);
    expect_state("R10 foreign done", 4'h1, 8'h08);
  endtask

  task automatic t_done;
    step(4'h1, 8'h00, 4'h0, 8'h00);
    expect_state("R7 retrigger", 4'h1, 8'h08);
    step(4'h0, 8'h00, 4'h1, 8'h00);
    expect_state("R4 pf0 clear", 4'h0, 8'h08);
    step(4'h0, 8'h00, 4'h0, 8'h08);
    expect_state("R4 vf3 clear", 4'h0, 8'h00);
  endtask

  task automatic t_done_idle;
    step(4'h0, 8'h04, 4'h0, 8'h00);
    step(4'h2, 8'h00, 4'h0, 8'h00);
    step(4'h1, 8'h00, 4'h1, 8'h01);
    expect_state("R6 pf0 trig+done from idle", 4'h3, 8'h04);
    step(4'h0, 8'h00, 4'h0, 8'h01);
    expect_state("R5 vf0 done idle", 4'h3, 8'h04);
    step(4'h2, 8'h00, 4'h2, 8'h00);
    expect_state("R6 pf1 busy trig+done", 4'h3, 8'h04);
    step(4'h3, 8'h04, 4'h3, 8'h04);
    expect_state("R6 all busy trig+done", 4'h3, 8'h04);
    step(4'h3, 8'h00, 4'h0, 8'h04);
    expect_state("R7 retrig with done elsewhere", 4'h3, 8'h00);
    step(4'h0, 8'h00, 4'h3, 8'h00);
    expect_state("R4 clear both pf", 4'h0, 8'h00);
    step(4'h3, 8'h00, 4'h0, 8'h00);
    step(4'h0, 8'h00, 4'h3, 8'h3F);
    step(4'h0, 8'h00, 4'h3, 8'h3F);
    expect_state("R5 repeated done on idle", 4'h0, 8'h00);
  endtask

  task automatic t_reserved;
    step(4'hC, 8'hC0, 4'h0, 8'h00);
    expect_state("R8 reserved trig", 4'h0, 8'h00);
    step(4'hF, 8'hFF, 4'h0, 8'h00);
    expect_state("R8 all trig", 4'h3, 8'h3F);
    step(4'h0, 8'h00, 4'hC, 8'hC0);
    expect_state("R8 reserved done", 4'h3, 8'h3F);
    step(4'h0, 8'h00, 4'hF, 8'hFF);
    expect_state("R8 all done", 4'h0, 8'h00);
  endtask

  initial begin
    t_reset;
    t_set_hold;
    t_done;
    t_done_idle;
    t_reserved;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule